// File: doc/BRIEF.md
# I2C Bit-Level Timing Engine

This block sits between a byte-level sequencer and the two open-drain wires of an I2C bus. The sequencer hands it one primitive at a time: start, repeated start, stop, write bit or read bit. The engine turns each primitive into SCL and SDA waveforms. Every interval of a waveform is taken from its own count input, measured in base clock cycles. No two intervals are derived from a common divider, so low and high periods, setup and hold times and the SDA hold and sample points can each be tuned alone. A typical setting uses half a bus period for each SCL phase, a quarter period for the start and stop setup and hold times, and an eighth of a period for the SDA hold and sample points.

The engine never drives either line high. An output enable of 1 pulls the wire low, and 0 lets the pull-up raise it. The engine reads the sensed wire levels back. This gives three things. A device that holds SCL low stretches the high phase. A mismatch on SDA while the engine sends a 1 ends the primitive with arbitration lost. A small bus monitor reports whether the bus is between a start and a stop condition.

A primitive is accepted in a cycle where `req_ready` and `req_valid` are both high. `done` pulses for one cycle when the primitive completes. In that same cycle `req_ready` is high again.

Top module: `i2c_phase_engine`

## Requirements
- R1: After reset both output enables are 0, `req_ready` is 1, and `done`, `arb_lost` and `bus_busy` are 0.
- R2: The start primitive (opcode 0) starts from a released bus.
  - It drives SDA low with SCL released for max(t_start_hold,1) cycles.
  - It then drives SCL low and pulses `done`.
  - `bus_busy` rises one cycle after SDA is sensed falling while SCL is sensed high.
- R3: A write bit (opcode 3) or a read bit (opcode 4) keeps SCL driven low for max(t_low,1) cycles, counted from the cycle after acceptance.
  - SDA keeps its old level through cycle min(t_sda_hold, low-1) of that phase.
  - From the next cycle on, SDA carries the new level: driven low for a write of 0, released for a write of 1 or a read.
- R4: In the high phase SCL is released. The phase lasts max(t_high,1) cycles counted from the first cycle SCL is sensed high, so while another device holds SCL low, the phase does not advance. SCL is then driven low again together with `done`.
- R5: A read releases SDA. `rx_bit` takes the sensed SDA level t_sda_sample cycles after SCL is first sensed high, given t_sda_sample < t_high. It holds that value until the next sample.
- R6: During the high phase of a write of 1, if SDA is sensed low while SCL is sensed high, then in the next cycle both lines are released, `arb_lost` pulses for one cycle, `req_ready` returns and `done` stays 0.
- R7: The stop primitive (opcode 2) runs in three steps, then pulses `done`:
  - It drives SDA low after the hold point of a max(t_low,1)-cycle low phase.
  - It releases SCL for max(t_stop_setup,1) cycles counted from the sensed SCL rise.
  - It releases SDA for max(t_stop_hold,1) cycles.
  - `bus_busy` falls once SDA is sensed rising while SCL is sensed high.
- R8: The repeated start primitive (opcode 1) runs in four steps, then pulses `done`:
  - It releases SDA after the hold point of a max(t_low,1)-cycle low phase.
  - It releases SCL for max(t_rs_setup,1) cycles counted from the sensed SCL rise.
  - It drives SDA low for max(t_start_hold,1) cycles.
  - It drives SCL low.
- R9: A request made while `req_ready` is 0 is ignored. A request with an opcode of 5, 6 or 7 is ignored. Neither one changes the lines or `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Primitive request |
| req_op | input | 3 | 0 start, 1 repeated start, 2 stop, 3 write bit, 4 read bit |
| req_bit | input | 1 | Bit value for a write |
| req_ready | output | 1 | Engine idle, request accepted |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last sampled SDA level |
| arb_lost | output | 1 | One-cycle arbitration-lost pulse |
| bus_busy | output | 1 | Bus between a start and a stop condition |
| t_low | input | CW | SCL low period |
| t_high | input | CW | SCL high period |
| t_start_hold | input | CW | Start hold time |
| t_rs_setup | input | CW | Repeated-start setup time |
| t_stop_setup | input | CW | Stop setup time |
| t_stop_hold | input | CW | Stop hold time |
| t_sda_hold | input | CW | SDA change point after SCL falls |
| t_sda_sample | input | CW | SDA sample point after SCL rises |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions check on every cycle that:
- an arbitration loss leaves both lines released and never coincides with `done`;
- `done` only appears while the engine is idle;
- a bad opcode keeps the engine idle;
- a high phase cannot end while SCL is sensed low;
- `bus_busy` only rises on a sensed start condition.

The exact phase lengths, the cycle in which SDA moves after the hold point, the sampled read value and the stretch-extended high phase are shown only by the bench. It replays the requirements as a cycle-by-cycle waveform model under two timing settings, with another device stretching the clock or pulling SDA low.

// File: rtl/i2c_phase_pkg.sv
package i2c_phase_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_BIT_LOW,
        PH_BIT_HIGH,
        PH_STP_LOW,
        PH_STP_SETUP,
        PH_STP_HOLD,
        PH_RS_LOW,
        PH_RS_SETUP,
        PH_ST_HOLD
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   scl_oe;
        logic   sda_oe;
        logic   bit_v;
        logic   wr;
        logic   rx;
        logic   done;
        logic   arb;
    } eng_t;

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    input  logic [CW-1:0] mark,
    output logic          last,
    output logic          at_mark
);
    localparam int EW = CW + 1;

    logic [CW-1:0] el_d, el_q;
    logic [EW-1:0] el_next;

    assign el_next = {1'b0, el_q} + EW'(1);
    // A limit of 0 behaves as 1: the compare is against elapsed+1.
    assign last    = run && (el_next >= {1'b0, limit});
    assign at_mark = run && (el_q == mark);

    always_comb begin
        el_d = el_q;
        if (clear) begin
            el_d = '0;
        end else if (run && !last) begin
            el_d = el_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            el_q <= '0;
        end else begin
            el_q <= el_d;
        end
    end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    logic busy_d, busy_q;
    logic sda_prev_d, sda_prev_q;

    always_comb begin
        busy_d     = busy_q;
        sda_prev_d = sda_in;
        if (scl_in && sda_prev_q && !sda_in) begin
            busy_d = 1'b1;
        end else if (scl_in && !sda_prev_q && sda_in) begin
            busy_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            sda_prev_q <= 1'b1;
        end else begin
            busy_q     <= busy_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/i2c_phase_engine.sv
module i2c_phase_engine
    import i2c_phase_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic          req_bit,
    output logic          req_ready,
    output logic          done,
    output logic          rx_bit,
    output logic          arb_lost,
    output logic          bus_busy,
    input  logic [CW-1:0] t_low,
    input  logic [CW-1:0] t_high,
    input  logic [CW-1:0] t_start_hold,
    input  logic [CW-1:0] t_rs_setup,
    input  logic [CW-1:0] t_stop_setup,
    input  logic [CW-1:0] t_stop_hold,
    input  logic [CW-1:0] t_sda_hold,
    input  logic [CW-1:0] t_sda_sample,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe
);
    eng_t          s_d, s_q;
    logic [CW-1:0] limit, mark;
    logic          run, last, at_mark, clear;
    logic          high_phase;

    // Phase interval selection; the phases that release SCL only count
    // while SCL is sensed high, which is how clock stretching is honoured.
    always_comb begin
        limit = '0;
        mark  = '0;
        run   = 1'b1;
        case (s_q.ph)
            PH_BIT_LOW, PH_STP_LOW, PH_RS_LOW: begin
                limit = t_low;
                mark  = t_sda_hold;
            end
            PH_BIT_HIGH: begin
                limit = t_high;
                mark  = t_sda_sample;
                run   = scl_in;
            end
            PH_STP_SETUP: begin
                limit = t_stop_setup;
                run   = scl_in;
            end
            PH_RS_SETUP: begin
                limit = t_rs_setup;
                run   = scl_in;
            end
            PH_STP_HOLD: limit = t_stop_hold;
            PH_ST_HOLD:  limit = t_start_hold;
            default:     run = 1'b0;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.arb  = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    case (req_op)
                        OP_START: begin
                            s_d.ph     = PH_ST_HOLD;
                            s_d.sda_oe = 1'b1;
                            s_d.scl_oe = 1'b0;
                        end
                        OP_RESTART: begin
                            s_d.ph     = PH_RS_LOW;
                            s_d.scl_oe = 1'b1;
                        end
                        OP_STOP: begin
                            s_d.ph     = PH_STP_LOW;
                            s_d.scl_oe = 1'b1;
                        end
                        OP_WRITE, OP_READ: begin
                            s_d.ph     = PH_BIT_LOW;
                            s_d.scl_oe = 1'b1;
                            s_d.wr     = (req_op == OP_WRITE);
                            s_d.bit_v  = (req_op == OP_WRITE) ? req_bit : 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            PH_BIT_LOW: begin
                if (at_mark || last) s_d.sda_oe = ~s_q.bit_v;
                if (last) begin
                    s_d.ph     = PH_BIT_HIGH;
                    s_d.scl_oe = 1'b0;
                end
            end
            PH_BIT_HIGH: begin
                if (scl_in && s_q.wr && s_q.bit_v && !sda_in) begin
                    s_d.ph     = PH_IDLE;
                    s_d.scl_oe = 1'b0;
                    s_d.sda_oe = 1'b0;
                    s_d.arb    = 1'b1;
                end else begin
                    if (at_mark) s_d.rx = sda_in;
                    if (last) begin
                        s_d.ph     = PH_IDLE;
                        s_d.scl_oe = 1'b1;
                        s_d.done   = 1'b1;
                    end
                end
            end
            PH_STP_LOW: begin
                if (at_mark || last) s_d.sda_oe = 1'b1;
                if (last) begin
                    s_d.ph     = PH_STP_SETUP;
                    s_d.scl_oe = 1'b0;
                end
            end
            PH_STP_SETUP: begin
                if (last) begin
                    s_d.ph     = PH_STP_HOLD;
                    s_d.sda_oe = 1'b0;
                end
            end
            PH_STP_HOLD: begin
                if (last) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            end
            PH_RS_LOW: begin
                if (at_mark || last) s_d.sda_oe = 1'b0;
                if (last) begin
                    s_d.ph     = PH_RS_SETUP;
                    s_d.scl_oe = 1'b0;
                end
            end
            PH_RS_SETUP: begin
                if (last) begin
                    s_d.ph     = PH_ST_HOLD;
                    s_d.sda_oe = 1'b1;
                end
            end
            PH_ST_HOLD: begin
                if (last) begin
                    s_d.ph     = PH_IDLE;
                    s_d.scl_oe = 1'b1;
                    s_d.done   = 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    assign clear = (s_d.ph != s_q.ph);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    i2c_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .run     (run),
        .limit   (limit),
        .mark    (mark),
        .last    (last),
        .at_mark (at_mark)
    );

    i2c_bus_watch u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .busy   (bus_busy)
    );

    assign high_phase = (s_q.ph == PH_BIT_HIGH);
    assign req_ready  = (s_q.ph == PH_IDLE);
    assign done       = s_q.done;
    assign arb_lost   = s_q.arb;
    assign rx_bit     = s_q.rx;
    assign scl_oe     = s_q.scl_oe;
    assign sda_oe     = s_q.sda_oe;
endmodule

// File: rtl/i2c_phase_engine_chk.sv
module i2c_phase_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       req_ready,
    input logic       done,
    input logic       arb_lost,
    input logic       bus_busy,
    input logic       scl_in,
    input logic       sda_in,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       high_phase
);
    AST_ARB_RELEASES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!scl_oe && !sda_oe && req_ready)); // R6

    AST_ARB_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_lost && done)); // R6

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R9

    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && (req_op > 3'd4)) |=> req_ready); // R9

    AST_STRETCH_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (high_phase && !scl_in) |=> high_phase); // R4

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> ($past(scl_in) && !$past(sda_in))); // R2
endmodule

bind i2c_phase_engine i2c_phase_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_ready  (req_ready),
    .done       (done),
    .arb_lost   (arb_lost),
    .bus_busy   (bus_busy),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .high_phase (high_phase)
);

// File: tb/i2c_phase_engine_bench.sv
module i2c_phase_engine_bench;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic req_bit = 1'b0;
    logic req_ready, done, rx_bit, arb_lost, bus_busy;
    logic scl_oe, sda_oe, scl_in, sda_in;
    logic stretch = 1'b0;
    logic slv_low = 1'b0;

    int cL, cHi, cSh, cRs, cPs, cPh, cH, cSm;
    int total = 0;
    int bad = 0;
    bit cur_sda = 1'b0;

    always #5 clk = ~clk;

    // Open-drain wires with pull-ups; another device may hold either low.
    assign scl_in = ~scl_oe & ~stretch;
    assign sda_in = ~(sda_oe | slv_low);

    i2c_phase_engine #(.CW(CW)) u_i2c_phase_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_bit      (req_bit),
        .req_ready    (req_ready),
        .done         (done),
        .rx_bit       (rx_bit),
        .arb_lost     (arb_lost),
        .bus_busy     (bus_busy),
        .t_low        (CW'(cL)),
        .t_high       (CW'(cHi)),
        .t_start_hold (CW'(cSh)),
        .t_rs_setup   (CW'(cRs)),
        .t_stop_setup (CW'(cPs)),
        .t_stop_hold  (CW'(cPh)),
        .t_sda_hold   (CW'(cH)),
        .t_sda_sample (CW'(cSm)),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe)
    );

    function automatic int eff(int n);
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int low_mark();
        return (cH < eff(cL) - 1) ? cH : eff(cL) - 1;
    endfunction

    task automatic chk1(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Compare one cycle of the model, then move to the next cycle.
    task automatic cyc(string tag, bit escl, bit esda, bit erdy, bit edone, bit earb);
        total++;
        if (scl_oe !== escl || sda_oe !== esda || req_ready !== erdy ||
            done !== edone || arb_lost !== earb) begin
            bad++;
            $display("FAIL %s: got scl=%b sda=%b rdy=%b done=%b arb=%b expected %b %b %b %b %b",
                     tag, scl_oe, sda_oe, req_ready, done, arb_lost,
                     escl, esda, erdy, edone, earb);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic issue(logic [2:0] op, bit b);
        req_valid = 1'b1;
        req_op    = op;
        req_bit   = b;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic do_start(string tag);
        issue(3'd0, 1'b0);
        for (int k = 0; k < eff(cSh); k++) cyc(tag, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cur_sda = 1'b1;
        chk1({tag, " busy"}, bus_busy, 1'b1);
        cyc(tag, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic do_bit(string tag, bit is_wr, bit b, int s, bit slow, bit inject);
        bit nb;
        int lm;
        nb = is_wr ? ~b : 1'b0;
        lm = low_mark();
        slv_low = slow;
        stretch = (s > 0);
        issue(is_wr ? 3'd3 : 3'd4, b);
        for (int k = 0; k < eff(cL); k++) begin
            if (inject && k == 1) begin
                req_valid = 1'b1;
                req_op    = 3'd2;
            end
            cyc(tag, 1'b1, (k > lm) ? nb : cur_sda, 1'b0, 1'b0, 1'b0);
            req_valid = 1'b0;
        end
        cur_sda = nb;
        if (is_wr && b && slow) begin
            cyc(tag, 1'b0, nb, 1'b0, 1'b0, 1'b0);
            cyc(tag, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            slv_low = 1'b0;
            cur_sda = 1'b0;
            return;
        end
        for (int k = 0; k < s + eff(cHi); k++) begin
            if (k == s) stretch = 1'b0;
            cyc(tag, 1'b0, cur_sda, 1'b0, 1'b0, 1'b0);
        end
        if (!is_wr) chk1({tag, " rx"}, rx_bit, ~slow);
        cyc(tag, 1'b1, cur_sda, 1'b1, 1'b1, 1'b0);
        slv_low = 1'b0;
    endtask

    task automatic do_stop(string tag, int s);
        int lm;
        lm = low_mark();
        stretch = (s > 0);
        issue(3'd2, 1'b0);
        for (int k = 0; k < eff(cL); k++) cyc(tag, 1'b1, (k > lm) ? 1'b1 : cur_sda, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < s + eff(cPs); k++) begin
            if (k == s) stretch = 1'b0;
            cyc(tag, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        for (int k = 0; k < eff(cPh); k++) cyc(tag, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cur_sda = 1'b0;
        chk1({tag, " busy"}, bus_busy, 1'b0);
        cyc(tag, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic do_restart(string tag, int s);
        int lm;
        lm = low_mark();
        stretch = (s > 0);
        issue(3'd1, 1'b0);
        for (int k = 0; k < eff(cL); k++) cyc(tag, 1'b1, (k > lm) ? 1'b0 : cur_sda, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < s + eff(cRs); k++) begin
            if (k == s) stretch = 1'b0;
            cyc(tag, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        for (int k = 0; k < eff(cSh); k++) cyc(tag, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cur_sda = 1'b1;
        chk1({tag, " busy"}, bus_busy, 1'b1);
        cyc(tag, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got running expected finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cL = 6; cHi = 5; cSh = 3; cRs = 4; cPs = 3; cPh = 4; cH = 2; cSm = 2;
        repeat (3) @(posedge clk);
        #1;
        chk1("R1 busy", bus_busy, 1'b0);
        chk1("R1 rx", rx_bit, 1'b0);
        cyc("R1 reset", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        cyc("R1 after reset", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        // First timing setting: hold point inside the low phase.
        do_start("R2 start");
        do_bit("R3 R4 write1", 1'b1, 1'b1, 0, 1'b0, 1'b0);
        do_bit("R3 R4 write0", 1'b1, 1'b0, 0, 1'b0, 1'b0);
        do_bit("R5 read0", 1'b0, 1'b0, 0, 1'b1, 1'b0);
        do_bit("R5 read1", 1'b0, 1'b0, 0, 1'b0, 1'b0);
        do_bit("R4 stretch write1", 1'b1, 1'b1, 3, 1'b0, 1'b0);
        do_restart("R8 restart", 2);
        do_bit("R9 busy request write0", 1'b1, 1'b0, 0, 1'b0, 1'b1);
        issue(3'd7, 1'b0);
        cyc("R9 bad opcode 7", 1'b1, cur_sda, 1'b1, 1'b0, 1'b0);
        do_stop("R7 stop", 1);
        issue(3'd5, 1'b1);
        cyc("R9 bad opcode 5", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        // Second timing setting: zero counts and a hold point past the low phase.
        cL = 3; cHi = 2; cSh = 0; cRs = 0; cPs = 0; cPh = 0; cH = 7; cSm = 0;
        do_start("R2 start min");
        do_bit("R3 late hold write0", 1'b1, 1'b0, 0, 1'b0, 1'b0);
        do_bit("R5 R4 stretch read0", 1'b0, 1'b0, 2, 1'b1, 1'b0);
        do_restart("R8 restart min", 0);
        do_bit("R5 read1 min", 1'b0, 1'b0, 0, 1'b0, 1'b0);
        do_stop("R7 stop min", 0);

        // Arbitration loss on a write of 1.
        cL = 4; cHi = 4; cSh = 2; cH = 1; cSm = 1;
        do_start("R2 start arb");
        do_bit("R6 arbitration", 1'b1, 1'b1, 0, 1'b1, 1'b0);
        cyc("R6 after arb", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule